// File: doc/BRIEF.md
# Externally Clocked 8-bit Timer/Counter

This block is an 8-bit up-counter whose count pulses come from one of two kinds of source. The first kind is a set of free-running prescaler tick strobes that are already in the system clock domain. The second is an asynchronous external pin, which is sampled, synchronized and edge-detected before it can move the count. A 3-bit clock-select field picks the source. It can also stop the counter. The external source is never divided: each qualifying pin edge gives exactly one count pulse.

The count climbs by one on each selected pulse. After it reaches its TOP value, the next pulse returns it to zero. TOP is either the full-scale value 0xFF or a programmable compare value, chosen by a CTC mode bit. Software can load the count through a write port and reads it back directly. A top-reached signal shows when the count equals TOP. A sticky overflow request flag records each pass through 0xFF until software clears it.

Top module: `ext_clk_timer8`

## Requirements
- R1: While reset is asserted, and directly after it, the count is 0, the overflow flag is 0 and the count-enable strobe is 0.
- R2: With clock-select code 0, the count does not change, whatever the prescaler ticks or the pin do.
- R3: Clock-select codes 1 to 5 choose prescaler tick bit (code-1). A cycle with that bit high raises the count by exactly one at that clock edge. The other tick bits have no effect.
- R4: Code 7 counts rising pin edges. The pin is sampled on the falling clock edge. count-enable is high for one cycle, between the second and third rising edges after that sample. The count changes at the third rising edge, and falling pin edges do not count.
- R5: Code 6 counts falling pin edges with the same latency as R4, and rising pin edges do not count.
- R6: With an external code, the prescaler ticks are ignored. Each qualifying pin edge adds exactly one, provided each pin level lasts at least two system cycles.
- R7: With the CTC bit clear, TOP is 0xFF. A pulse at 0xFF returns the count to 0.
- R8: With the CTC bit set, TOP is the compare value. A pulse while the count equals it returns the count to 0. A count above the compare value keeps rising until it wraps past 0xFF.
- R9: top-reached is high exactly when the count equals TOP. It is forced low in any cycle in which the count write strobe is high.
- R10: The overflow flag is set by a pulse while the count is 0xFF, and it then stays set. A cycle with the clear input high clears it at the next edge. When a set and a clear fall in the same cycle, the set wins.
- R11: A count write loads the written value at the next edge. It takes priority over an increment or wrap in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| extPin | input | 1 | Asynchronous external count pin |
| prescTicks | input | 5 | Prescaler tick strobes; bit k is used by select code k+1 |
| clkSel | input | 3 | Clock select: 0 stop, 1-5 prescaler, 6 pin falling, 7 pin rising |
| ctcMode | input | 1 | 1: TOP is topValue; 0: TOP is 0xFF |
| topValue | input | 8 | Compare value used as TOP in CTC mode |
| cntWrEn | input | 1 | Count write strobe |
| cntWrData | input | 8 | Value written to the count |
| ovfClr | input | 1 | Write-one clear of the overflow flag |
| countValue | output | 8 | Current count |
| countEnable | output | 1 | Selected count pulse for this cycle |
| topReached | output | 1 | Count equals TOP and no write this cycle |
| ovfIrq | output | 1 | Sticky overflow interrupt request |

## Verification
Prescaler pulses, writes and flag clears all take effect at the first rising edge after they are driven. The bench therefore drives just after a rising edge and samples late in the same cycle, once that edge has passed. A pin edge is seen at the next falling edge. countEnable then rises after the second rising edge, and the count moves at the third. The bench checks the strobe and the unchanged count in each of those cycles before it checks the new value. top-reached is combinational, so it is read a moment after its inputs are driven. Checks that something was ignored wait at least five cycles, which is longer than the pin path, before they read the count.

// File: rtl/timer8_pkg.sv
package timer8_pkg;
  localparam int SEL_W = 3;
  localparam int SEL_CODES = 1 << SEL_W;
  localparam logic [SEL_W-1:0] SEL_STOP     = 3'd0;
  localparam logic [SEL_W-1:0] SEL_EXT_FALL = 3'd6;
  localparam logic [SEL_W-1:0] SEL_EXT_RISE = 3'd7;
  localparam int MAX_PRESC = 5;

  typedef struct packed {
    logic step;   // advance the count this cycle
    logic load;   // overwrite the count this cycle
  } ctlStrobe_t;
endpackage

// File: rtl/timer8_pin_sync.sv
module timer8_pin_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic pinIn,
  output logic riseEvt,
  output logic fallEvt
);
  localparam int LAST = SYNC_STAGES;

  logic negSample;
  logic [LAST:0] chain;

  // first capture on the opposite clock phase
  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) negSample <= 1'b0;
    else       negSample <= pinIn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain[0] <= 1'b0;
    else       chain[0] <= negSample;
  end

  for (genvar g = 1; g <= LAST; g++) begin : gStage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chain[g] <= 1'b0;
      else       chain[g] <= chain[g-1];
    end
  end

  assign riseEvt = chain[LAST-1] & ~chain[LAST];
  assign fallEvt = ~chain[LAST-1] & chain[LAST];

  AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    riseEvt |=> !riseEvt); // R6
  AST_FALL_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    fallEvt |=> !fallEvt); // R6
endmodule

// File: rtl/timer8_ctrl.sv
module timer8_ctrl
  import timer8_pkg::*;
#(
  parameter int PRESC_N     = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             extPin,
  input  logic [PRESC_N-1:0] prescTicks,
  input  logic [SEL_W-1:0] clkSel,
  input  logic             cntWrEn,
  output ctlStrobe_t       strobes,
  output logic             countEnable
);
  logic riseEvt, fallEvt;
  logic [SEL_CODES-1:0] tickByCode;

  timer8_pin_sync #(.SYNC_STAGES(SYNC_STAGES)) uSync (
    .clk(clk), .rstN(rstN), .pinIn(extPin),
    .riseEvt(riseEvt), .fallEvt(fallEvt)
  );

  assign tickByCode[0] = 1'b0;
  for (genvar g = 1; g <= MAX_PRESC; g++) begin : gPresc
    if (g <= PRESC_N) begin : gUsed
      assign tickByCode[g] = prescTicks[g-1];
    end else begin : gUnused
      assign tickByCode[g] = 1'b0;
    end
  end
  assign tickByCode[SEL_EXT_FALL] = fallEvt;
  assign tickByCode[SEL_EXT_RISE] = riseEvt;

  assign countEnable  = tickByCode[clkSel];
  assign strobes.load = cntWrEn;
  assign strobes.step = countEnable & ~cntWrEn;

  AST_STOPPED: assert property (@(posedge clk) disable iff (!rstN)
    (clkSel == SEL_STOP) |-> !countEnable); // R2
  AST_EXT_IGNORES_PRESC: assert property (@(posedge clk) disable iff (!rstN)
    (clkSel == SEL_EXT_RISE) |-> (countEnable == riseEvt)); // R6
endmodule

// File: rtl/timer8_datapath.sv
module timer8_datapath
  import timer8_pkg::*;
#(
  parameter int COUNT_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctlStrobe_t         strobes,
  input  logic               ctcMode,
  input  logic [COUNT_W-1:0] topValue,
  input  logic [COUNT_W-1:0] cntWrData,
  input  logic               ovfClr,
  output logic [COUNT_W-1:0] countValue,
  output logic               topReached,
  output logic               ovfIrq
);
  localparam logic [COUNT_W-1:0] FULL = '1;

  logic [COUNT_W-1:0] topLimit;
  logic atTop, atFull, ovfSet;

  assign topLimit   = ctcMode ? topValue : FULL;
  assign atTop      = (countValue == topLimit);
  assign atFull     = (countValue == FULL);
  assign topReached = atTop & ~strobes.load;
  assign ovfSet     = strobes.step & atFull;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              countValue <= '0;
    else if (strobes.load)  countValue <= cntWrData;
    else if (strobes.step)  countValue <= atTop ? '0 : countValue + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       ovfIrq <= 1'b0;
    else if (ovfSet) ovfIrq <= 1'b1;
    else if (ovfClr) ovfIrq <= 1'b0;
  end

  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rstN)
    strobes.load |=> countValue == $past(cntWrData)); // R11
  AST_WRAP_TOP: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.step && !strobes.load && atTop) |=> countValue == '0); // R8
  AST_INC_ONE: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.step && !strobes.load && !atTop) |=>
      countValue == COUNT_W'($past(countValue) + 1'b1)); // R3
  AST_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.step && !strobes.load) |=> $stable(countValue)); // R2
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (ovfIrq && !ovfClr) |=> ovfIrq); // R10
  AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.step && !strobes.load && atFull) |=> ovfIrq); // R10
endmodule

// File: rtl/ext_clk_timer8.sv
module ext_clk_timer8
  import timer8_pkg::*;
#(
  parameter int COUNT_W     = 8,
  parameter int PRESC_N     = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               extPin,
  input  logic [PRESC_N-1:0] prescTicks,
  input  logic [SEL_W-1:0]   clkSel,
  input  logic               ctcMode,
  input  logic [COUNT_W-1:0] topValue,
  input  logic               cntWrEn,
  input  logic [COUNT_W-1:0] cntWrData,
  input  logic               ovfClr,
  output logic [COUNT_W-1:0] countValue,
  output logic               countEnable,
  output logic               topReached,
  output logic               ovfIrq
);
  ctlStrobe_t strobes;

  timer8_ctrl #(.PRESC_N(PRESC_N), .SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .clk(clk), .rstN(rstN), .extPin(extPin), .prescTicks(prescTicks),
    .clkSel(clkSel), .cntWrEn(cntWrEn), .strobes(strobes),
    .countEnable(countEnable)
  );

  timer8_datapath #(.COUNT_W(COUNT_W)) uData (
    .clk(clk), .rstN(rstN), .strobes(strobes), .ctcMode(ctcMode),
    .topValue(topValue), .cntWrData(cntWrData), .ovfClr(ovfClr),
    .countValue(countValue), .topReached(topReached), .ovfIrq(ovfIrq)
  );

  AST_RESET_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (countValue == '0 && !ovfIrq)); // R1
endmodule

// File: tb/tb_ext_clk_timer8.sv
module tb_ext_clk_timer8;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic extPin = 1'b0;
  logic [4:0] prescTicks = '0;
  logic [2:0] clkSel = '0;
  logic ctcMode = 1'b0;
  logic [7:0] topValue = '0;
  logic cntWrEn = 1'b0;
  logic [7:0] cntWrData = '0;
  logic ovfClr = 1'b0;
  logic [7:0] countValue;
  logic countEnable, topReached, ovfIrq;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  ext_clk_timer8 dut (
    .clk(clk), .rstN(rstN), .extPin(extPin), .prescTicks(prescTicks),
    .clkSel(clkSel), .ctcMode(ctcMode), .topValue(topValue),
    .cntWrEn(cntWrEn), .cntWrData(cntWrData), .ovfClr(ovfClr),
    .countValue(countValue), .countEnable(countEnable),
    .topReached(topReached), .ovfIrq(ovfIrq)
  );

  typedef struct packed {
    logic       ctc;
    logic [7:0] top;
    logic [2:0] sel;
    logic [4:0] ticks;
    logic       wr;
    logic [7:0] data;
    logic [7:0] expCnt;
    logic       expTop;
    logic       expFlag;
  } vec_t;

  localparam int NVEC = 15;
  localparam logic [35:0] VECS [NVEC] = '{
    {1'b0, 8'h00, 3'd1, 5'b00001, 1'b0, 8'h00, 8'h01, 1'b0, 1'b0}, // R3
    {1'b0, 8'h00, 3'd1, 5'b00010, 1'b0, 8'h00, 8'h01, 1'b0, 1'b0}, // R3 other bit
    {1'b0, 8'h00, 3'd2, 5'b00010, 1'b0, 8'h00, 8'h02, 1'b0, 1'b0}, // R3
    {1'b0, 8'h00, 3'd5, 5'b10000, 1'b0, 8'h00, 8'h03, 1'b0, 1'b0}, // R3
    {1'b0, 8'h00, 3'd5, 5'b01111, 1'b0, 8'h00, 8'h03, 1'b0, 1'b0}, // R3 other bits
    {1'b0, 8'h00, 3'd0, 5'b11111, 1'b0, 8'h00, 8'h03, 1'b0, 1'b0}, // R2
    {1'b0, 8'h00, 3'd1, 5'b00001, 1'b1, 8'hFE, 8'hFE, 1'b0, 1'b0}, // R11
    {1'b0, 8'h00, 3'd1, 5'b00001, 1'b0, 8'h00, 8'hFF, 1'b1, 1'b0}, // R9
    {1'b0, 8'h00, 3'd1, 5'b00001, 1'b0, 8'h00, 8'h00, 1'b0, 1'b1}, // R7 R10
    {1'b1, 8'h03, 3'd0, 5'b00000, 1'b1, 8'h02, 8'h02, 1'b0, 1'b1}, // R11
    {1'b1, 8'h03, 3'd4, 5'b01000, 1'b0, 8'h00, 8'h03, 1'b1, 1'b1}, // R9
    {1'b1, 8'h03, 3'd4, 5'b01000, 1'b0, 8'h00, 8'h00, 1'b0, 1'b1}, // R8
    {1'b1, 8'h03, 3'd0, 5'b00000, 1'b1, 8'h05, 8'h05, 1'b0, 1'b1}, // R11
    {1'b1, 8'h03, 3'd3, 5'b00100, 1'b0, 8'h00, 8'h06, 1'b0, 1'b1}, // R8 above top
    {1'b1, 8'h06, 3'd3, 5'b00100, 1'b0, 8'h00, 8'h00, 1'b0, 1'b1}  // R8
  };

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    testsRun++;
    if (got !== exp) begin
      testsFailed++;
      $display("FAIL %s: actual %0h expected %0h", tag, got, exp);
    end
  endtask

  // drive phase: 2 ns after a rising edge; check phase: 15 ns after it
  task automatic toDrive();
    @(posedge clk);
    #2;
  endtask

  task automatic toCheck();
    #13;
  endtask

  task automatic idleCycles(input int n);
    for (int k = 0; k < n; k++) toDrive();
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      testsFailed++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    idleCycles(3);
    check("R1 count in reset", {8'h0, countValue}, 16'h0);
    check("R1 flag in reset", {15'h0, ovfIrq}, 16'h0);
    rstN = 1'b1;
    toCheck();
    check("R1 count after reset", {8'h0, countValue}, 16'h0);
    check("R1 enable after reset", {15'h0, countEnable}, 16'h0);
    check("R1 flag after reset", {15'h0, ovfIrq}, 16'h0);

    // table walk
    for (int i = 0; i < NVEC; i++) begin
      vec_t v;
      v = vec_t'(VECS[i]);
      toDrive();
      ctcMode = v.ctc; topValue = v.top; clkSel = v.sel;
      prescTicks = v.ticks; cntWrEn = v.wr; cntWrData = v.data;
      @(posedge clk);
      #3;
      prescTicks = '0; cntWrEn = 1'b0;
      #12;
      check($sformatf("R3/R7/R8/R11 vec%0d count", i), {8'h0, countValue}, {8'h0, v.expCnt});
      check($sformatf("R9 vec%0d top", i), {15'h0, topReached}, {15'h0, v.expTop});
      check($sformatf("R10 vec%0d flag", i), {15'h0, ovfIrq}, {15'h0, v.expFlag});
    end

    // R10 clear
    toDrive();
    clkSel = 3'd0; ovfClr = 1'b1;
    toDrive();
    ovfClr = 1'b0;
    toCheck();
    check("R10 flag cleared", {15'h0, ovfIrq}, 16'h0);

    // R10 set wins over clear
    toDrive();
    ctcMode = 1'b0; cntWrEn = 1'b1; cntWrData = 8'hFF;
    toDrive();
    cntWrEn = 1'b0; clkSel = 3'd1; prescTicks = 5'b00001; ovfClr = 1'b1;
    toDrive();
    prescTicks = '0; ovfClr = 1'b0;
    toCheck();
    check("R10 set wins flag", {15'h0, ovfIrq}, 16'h1);
    check("R7 wrap count", {8'h0, countValue}, 16'h0);
    toDrive();
    ovfClr = 1'b1;
    toDrive();
    ovfClr = 1'b0;

    // R9 write masks top match
    ctcMode = 1'b1; topValue = 8'h00; clkSel = 3'd0;
    #1;
    check("R9 match at compare", {15'h0, topReached}, 16'h1);
    cntWrEn = 1'b1; cntWrData = 8'h40;
    #1;
    check("R9 masked by write", {15'h0, topReached}, 16'h0);
    toDrive();
    cntWrEn = 1'b0; ctcMode = 1'b0;
    toCheck();
    check("R11 loaded", {8'h0, countValue}, 16'h40);

    // R4 rising edge latency, prescaler ignored (R6)
    toDrive();
    clkSel = 3'd7; prescTicks = 5'b11111;
    toDrive();
    extPin = 1'b1;
    toCheck();
    check("R4 cycle0 enable", {15'h0, countEnable}, 16'h0);
    toDrive(); toCheck();
    check("R4 cycle1 enable", {15'h0, countEnable}, 16'h0);
    toDrive(); toCheck();
    check("R4 cycle2 enable", {15'h0, countEnable}, 16'h1);
    check("R4 cycle2 count", {8'h0, countValue}, 16'h40);
    toDrive(); toCheck();
    check("R4 cycle3 count", {8'h0, countValue}, 16'h41);
    check("R4 cycle3 enable", {15'h0, countEnable}, 16'h0);
    toDrive();
    extPin = 1'b0;
    idleCycles(5);
    toCheck();
    check("R4 falling ignored", {8'h0, countValue}, 16'h41);

    // R5 falling edge
    toDrive();
    clkSel = 3'd6;
    toDrive();
    extPin = 1'b1;
    idleCycles(5);
    toCheck();
    check("R5 rising ignored", {8'h0, countValue}, 16'h41);
    toDrive();
    extPin = 1'b0;
    toDrive(); toDrive(); toCheck();
    check("R5 cycle2 enable", {15'h0, countEnable}, 16'h1);
    check("R5 cycle2 count", {8'h0, countValue}, 16'h41);
    toDrive(); toCheck();
    check("R5 cycle3 count", {8'h0, countValue}, 16'h42);

    // R6 burst of four rising edges, two cycles per level
    toDrive();
    clkSel = 3'd7;
    for (int p = 0; p < 8; p++) begin
      toDrive();
      extPin = ~extPin;
      toDrive();
    end
    idleCycles(5);
    toCheck();
    check("R6 one count per edge", {8'h0, countValue}, 16'h46);

    // R2 stopped with a toggling pin
    toDrive();
    clkSel = 3'd0;
    for (int p = 0; p < 8; p++) begin
      toDrive();
      extPin = ~extPin;
      toDrive();
    end
    idleCycles(5);
    toCheck();
    check("R2 stopped ignores pin", {8'h0, countValue}, 16'h46);
    check("R10 flag still clear", {15'h0, ovfIrq}, 16'h0);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule